// File: doc/BRIEF.md
# I2C Packet Header Decoder

This block sits between a transmit word FIFO and the bit-level engine of an I2C master. Software writes every transfer as a packet: three 32-bit header words followed, for a write, by payload words. The decoder reads the header words and checks that the packet is marked as I2C. It then presents one command record to the bit engine: target address, address width, direction, byte count, end-of-transfer action and the option flags.

For a write, the decoder unpacks the payload words into single bytes for the bit engine. The lowest byte of each word goes first. Bytes in the last word that lie beyond the byte count are discarded. For a read, the decoder takes bytes back from the bit engine and packs them into 32-bit words for the receive FIFO, using the same byte order. A final partial word is pushed as soon as its last byte arrives. Every edge of the block uses a valid/ready handshake, so a stall at any edge holds the data that is being offered.

Top module: `pkthdr_decoder`

## Requirements
- R1: After reset, cmdValid, wrByteValid, rdByteReady, rxValid and protoErr are low, and txReady is high, so the next word is taken as header word 0.
- R2: Header word 0 is checked at bit 4, the I2C protocol mark. If that bit is clear, the word is discarded and protoErr pulses high for one cycle. The following word is again treated as header word 0.
- R3: cmdLen equals header word 1 bits [LEN_W-1:0] plus one. Bits of word 1 above LEN_W-1 have no effect.
- R4: If bit 18 of header word 2 is set, cmdTenBit is 1 and cmdAddr is bits 9:0. If bit 18 is clear, cmdTenBit is 0 and cmdAddr is bits 7:1, zero-extended.
- R5: cmdEnd is 1 (repeated start) when bit 16 of word 2 is set. It is 2 (continue, no stop and no restart) when bit 15 is set and bit 16 is clear. It is 0 (stop) when both bits are clear.
- R6: cmdRead follows bit 19 of word 2, cmdContNak follows bit 21, cmdStartByte follows bit 20 and cmdHighSpeed follows bit 22.
- R7: The command is offered once per packet. It stays stable until cmdReady, and no payload is moved before the command is accepted.
- R8: On a write, exactly cmdLen bytes are offered. Inside each payload word they go out in the order bits 7:0, 15:8, 23:16, 31:24. wrByteLast is high only on the final byte.
- R9: In a partial final payload word, the bytes beyond the length are dropped. The next transmit word is taken as a new header word 0.
- R10: On a read, received bytes are packed starting with the lowest byte, four to a word, giving ceil(cmdLen/4) words. Unused upper bytes of a final partial word are zero.
- R11: A packed word is held on rxData until rxReady. rdByteReady stays low while a word is held and not being drained. A held word can drain in the same cycle that the next word completes.
- R12: An offered write byte stays stable on wrByte until wrByteReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txValid | input | 1 | Transmit FIFO word available |
| txData | input | 32 | Transmit FIFO word |
| txReady | output | 1 | Word is consumed this cycle when txValid is high |
| cmdValid | output | 1 | Command record offered |
| cmdReady | input | 1 | Bit engine accepts the command |
| cmdRead | output | 1 | Transfer direction, 1 = read |
| cmdTenBit | output | 1 | 10-bit addressing |
| cmdAddr | output | 10 | Target address |
| cmdLen | output | LEN_W+1 | Byte count |
| cmdEnd | output | 2 | End action: 0 stop, 1 repeated start, 2 continue |
| cmdContNak | output | 1 | Continue after a NAK |
| cmdStartByte | output | 1 | Send a start byte first |
| cmdHighSpeed | output | 1 | High-speed transfer |
| wrByteValid | output | 1 | Write byte offered |
| wrByte | output | 8 | Write byte |
| wrByteLast | output | 1 | Final byte of the packet |
| wrByteReady | input | 1 | Bit engine takes the byte |
| rdByteValid | input | 1 | Received byte available |
| rdByte | input | 8 | Received byte |
| rdByteReady | output | 1 | Decoder takes the received byte |
| rxValid | output | 1 | Packed receive word offered |
| rxData | output | 32 | Packed receive word |
| rxReady | input | 1 | Receive FIFO takes the word |
| protoErr | output | 1 | One-cycle pulse when a header word is dropped |

## Verification
On the read path, two things can happen in the same cycle: the word already held for the receive FIFO drains, and the byte that completes the next word is taken. Both write the single output register. The bench provokes this by throttling rxReady and rdByteValid at random while read packets with different lengths run. It counts the cycles in which a drain and a byte take coincide. It judges the result in two ways: the scoreboard must receive every expected word in order with no loss and no duplicate, and the hold check must see each stalled word stay unchanged.

// File: rtl/pkthdr_pkg.sv
package pkthdr_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTES   = WORD_W / 8;
  localparam int LANE_W  = $clog2(BYTES);
  localparam int FLAG_W  = 23;
  localparam int PROTO_B = 4;
  localparam int HS_B    = 22;
  localparam int NAKC_B  = 21;
  localparam int SBYTE_B = 20;
  localparam int READ_B  = 19;
  localparam int TEN_B   = 18;
  localparam int RSTRT_B = 16;
  localparam int CONT_B  = 15;

  typedef enum logic [1:0] {
    END_STOP    = 2'd0,
    END_RESTART = 2'd1,
    END_CONT    = 2'd2
  } endAct_t;

  typedef struct packed {
    logic capLen;
    logic capFlags;
    logic capWord;
    logic stepWr;
    logic stepRd;
  } dpCtl_t;
endpackage

// File: rtl/pkthdr_ctrl.sv
module pkthdr_ctrl
  import pkthdr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txValid,
  input  logic   protoBit,
  input  logic   cmdReady,
  input  logic   wrByteReady,
  input  logic   rdByteValid,
  input  logic   rxRoom,
  input  logic   isRead,
  input  logic   lastByte,
  input  logic   laneEnd,
  output logic   txReady,
  output logic   cmdValid,
  output logic   wrByteValid,
  output logic   rdByteReady,
  output logic   protoErr,
  output dpCtl_t ctl
);
  typedef enum logic [2:0] {
    S_HDR0, S_HDR1, S_HDR2, S_CMD, S_WFETCH, S_WSEND, S_RDATA
  } state_t;

  state_t state, nxt;
  logic   txFire;

  assign txReady     = (state == S_HDR0) || (state == S_HDR1) ||
                       (state == S_HDR2) || (state == S_WFETCH);
  assign txFire      = txValid && txReady;
  assign cmdValid    = (state == S_CMD);
  assign wrByteValid = (state == S_WSEND);
  assign rdByteReady = (state == S_RDATA) && rxRoom;

  always_comb begin
    ctl          = '0;
    ctl.capLen   = (state == S_HDR1) && txFire;
    ctl.capFlags = (state == S_HDR2) && txFire;
    ctl.capWord  = (state == S_WFETCH) && txFire;
    ctl.stepWr   = (state == S_WSEND) && wrByteReady;
    ctl.stepRd   = (state == S_RDATA) && rdByteValid && rxRoom;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_HDR0:   if (txFire && protoBit) nxt = S_HDR1;
      S_HDR1:   if (txFire) nxt = S_HDR2;
      S_HDR2:   if (txFire) nxt = S_CMD;
      S_CMD:    if (cmdReady) nxt = isRead ? S_RDATA : S_WFETCH;
      S_WFETCH: if (txFire) nxt = S_WSEND;
      S_WSEND:  if (wrByteReady) nxt = lastByte ? S_HDR0 : (laneEnd ? S_WFETCH : S_WSEND);
      S_RDATA:  if (ctl.stepRd && lastByte) nxt = S_HDR0;
      default:  nxt = S_HDR0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_HDR0;
      protoErr <= 1'b0;
    end else begin
      state    <= nxt;
      protoErr <= (state == S_HDR0) && txFire && !protoBit;
    end
  end

  // R7: only one edge of the block is active in any cycle
  p_one_role_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txReady, cmdValid, wrByteValid, rdByteReady}));

  // R2: after a dropped word the decoder is again waiting for header word 0
  p_proto_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (state == S_HDR0));

  // R7: an offered command is not withdrawn
  p_cmd_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid);
endmodule

// File: rtl/pkthdr_dp.sv
module pkthdr_dp
  import pkthdr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] txData,
  input  logic [7:0]        rdByte,
  input  logic              rxReady,
  output logic              isRead,
  output logic              lastByte,
  output logic              laneEnd,
  output logic              rxRoom,
  output logic              cmdTenBit,
  output logic [9:0]        cmdAddr,
  output logic [LEN_W:0]    cmdLen,
  output logic [1:0]        cmdEnd,
  output logic              cmdContNak,
  output logic              cmdStartByte,
  output logic              cmdHighSpeed,
  output logic [7:0]        wrByte,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData
);
  logic [LEN_W-1:0]  lenM1;
  logic [FLAG_W-1:0] flags;
  logic [LEN_W-1:0]  byteCnt;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] wordBuf;
  logic [WORD_W-1:0] packBuf;
  logic [WORD_W-1:0] merged;
  logic              pushRx;
  logic              unusedBits;

  assign unusedBits = ^{txData[WORD_W-1:FLAG_W], flags[17], flags[14:10]};

  assign isRead   = flags[READ_B];
  assign lastByte = (byteCnt == lenM1);
  assign laneEnd  = (lane == LANE_W'(BYTES - 1));
  assign rxRoom   = !rxValid || rxReady;

  assign cmdTenBit    = flags[TEN_B];
  assign cmdAddr      = flags[TEN_B] ? flags[9:0] : {3'b000, flags[7:1]};
  assign cmdLen       = {1'b0, lenM1} + (LEN_W + 1)'(1);
  assign cmdContNak   = flags[NAKC_B];
  assign cmdStartByte = flags[SBYTE_B];
  assign cmdHighSpeed = flags[HS_B];

  always_comb begin
    if (flags[RSTRT_B])     cmdEnd = END_RESTART;
    else if (flags[CONT_B]) cmdEnd = END_CONT;
    else                    cmdEnd = END_STOP;
  end

  assign wrByte = 8'(wordBuf >> {lane, 3'b000});
  assign merged = packBuf | (WORD_W'(rdByte) << {lane, 3'b000});
  assign pushRx = ctl.stepRd && (lastByte || laneEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenM1   <= '0;
      flags   <= '0;
      byteCnt <= '0;
      lane    <= '0;
      wordBuf <= '0;
      packBuf <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (ctl.capLen) lenM1 <= txData[LEN_W-1:0];
      if (ctl.capFlags) begin
        flags   <= txData[FLAG_W-1:0];
        byteCnt <= '0;
        lane    <= '0;
        packBuf <= '0;
      end
      if (ctl.capWord) wordBuf <= txData;
      if (ctl.stepWr || ctl.stepRd) begin
        byteCnt <= byteCnt + LEN_W'(1);
        lane    <= lane + LANE_W'(1);
      end
      if (ctl.stepRd) begin
        if (pushRx) begin
          rxData  <= merged;
          packBuf <= '0;
        end else begin
          packBuf <= merged;
        end
      end
      if (pushRx)       rxValid <= 1'b1;
      else if (rxReady) rxValid <= 1'b0;
    end
  end

  // R11: a stalled receive word is held unchanged
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid && $stable(rxData));
endmodule

// File: rtl/pkthdr_decoder.sv
module pkthdr_decoder
  import pkthdr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic [31:0]      txData,
  output logic             txReady,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic             cmdRead,
  output logic             cmdTenBit,
  output logic [9:0]       cmdAddr,
  output logic [LEN_W:0]   cmdLen,
  output logic [1:0]       cmdEnd,
  output logic             cmdContNak,
  output logic             cmdStartByte,
  output logic             cmdHighSpeed,
  output logic             wrByteValid,
  output logic [7:0]       wrByte,
  output logic             wrByteLast,
  input  logic             wrByteReady,
  input  logic             rdByteValid,
  input  logic [7:0]       rdByte,
  output logic             rdByteReady,
  output logic             rxValid,
  output logic [31:0]      rxData,
  input  logic             rxReady,
  output logic             protoErr
);
  dpCtl_t ctl;
  logic   isRead, lastByte, laneEnd, rxRoom;

  pkthdr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .protoBit(txData[PROTO_B]),
    .cmdReady(cmdReady), .wrByteReady(wrByteReady), .rdByteValid(rdByteValid),
    .rxRoom(rxRoom), .isRead(isRead), .lastByte(lastByte), .laneEnd(laneEnd),
    .txReady(txReady), .cmdValid(cmdValid), .wrByteValid(wrByteValid),
    .rdByteReady(rdByteReady), .protoErr(protoErr), .ctl(ctl)
  );

  pkthdr_dp #(.LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txData(txData), .rdByte(rdByte),
    .rxReady(rxReady), .isRead(isRead), .lastByte(lastByte), .laneEnd(laneEnd),
    .rxRoom(rxRoom), .cmdTenBit(cmdTenBit), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .cmdEnd(cmdEnd), .cmdContNak(cmdContNak), .cmdStartByte(cmdStartByte),
    .cmdHighSpeed(cmdHighSpeed), .wrByte(wrByte), .rxValid(rxValid), .rxData(rxData)
  );

  assign cmdRead    = isRead;
  assign wrByteLast = wrByteValid && lastByte;

  // R7: command fields frozen while offered
  p_cmd_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> $stable({cmdRead, cmdTenBit, cmdAddr, cmdLen, cmdEnd}));

  // R12: offered write byte held until taken
  p_wr_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid && !wrByteReady |=> wrByteValid && $stable(wrByte));

  // R8: nothing is offered after the final write byte is taken
  p_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid && wrByteReady && wrByteLast |=> !wrByteValid);

  // R11: received bytes are only taken when the output word has room
  p_rd_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdByteReady |-> (!rxValid || rxReady));
endmodule

// File: tb/test_pkthdr_decoder.sv
`timescale 1ns/1ps
module test_pkthdr_decoder;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, txValid, txReady, cmdValid, cmdReady, cmdRead, cmdTenBit;
  logic [31:0] txData, rxData;
  logic [9:0] cmdAddr;
  logic [LEN_W:0] cmdLen;
  logic [1:0] cmdEnd;
  logic cmdContNak, cmdStartByte, cmdHighSpeed;
  logic wrByteValid, wrByteLast, wrByteReady, rdByteValid, rdByteReady;
  logic [7:0] wrByte, rdByte;
  logic rxValid, rxReady, protoErr;

  pkthdr_decoder #(.LEN_W(LEN_W)) i_pkthdr_decoder (.*);

  typedef struct {
    bit rd; bit ten; logic [9:0] addr; int len; int endc; logic [2:0] misc;
  } cmdExp_t;

  logic [31:0] txQ[$];
  cmdExp_t     cmdQ[$];
  logic [8:0]  wrQ[$];
  logic [7:0]  rdQ[$];
  logic [31:0] rxQ[$];

  int errs = 0, checks = 0, expErr = 0, seenErr = 0, overlapCnt = 0, pct = 100;
  bit run = 0;
  bit rxHold = 0, wrHold = 0, cmdHold = 0;
  logic [31:0] rxSnap;
  logic [7:0]  wrSnap;
  logic [LEN_W+13:0] cmdSnap;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendPkt(input bit rd, input bit ten, input logic [9:0] addr,
                         input int endSel, input int len, input logic [2:0] misc);
    logic [31:0] w2, w;
    cmdExp_t c;
    int nw, idx;
    w2 = 32'h0002_0000;
    if (endSel == 1 || endSel == 3) w2[16] = 1'b1;
    if (endSel == 2 || endSel == 3) w2[15] = 1'b1;
    if (ten) begin w2[18] = 1'b1; w2[9:0] = addr; end
    else w2[7:1] = addr[6:0];
    w2[19] = rd; w2[21] = misc[0]; w2[20] = misc[1]; w2[22] = misc[2];
    txQ.push_back(32'h0001_0010 | (32'($urandom_range(15)) << 12));
    txQ.push_back(32'(len - 1) | 32'hA5C0_0000);
    txQ.push_back(w2);
    c.rd = rd; c.ten = ten; c.addr = ten ? addr : {3'b000, addr[6:0]};
    c.len = len; c.misc = misc;
    c.endc = (endSel == 1 || endSel == 3) ? 1 : (endSel == 2 ? 2 : 0);
    cmdQ.push_back(c);
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      w = $urandom();
      if (rd) begin
        for (int b = 0; b < 4; b++) begin
          idx = k * 4 + b;
          if (idx < len) rdQ.push_back(w[b*8 +: 8]);
          else w[b*8 +: 8] = 8'h00;
        end
        rxQ.push_back(w);
      end else begin
        for (int b = 0; b < 4; b++) begin
          idx = k * 4 + b;
          if (idx < len) wrQ.push_back({idx == len - 1, w[b*8 +: 8]});
        end
        txQ.push_back(w);
      end
    end
  endtask

  task automatic sendBad();
    txQ.push_back($urandom() & 32'hFFFF_FFEF);
    expErr++;
  endtask

  task automatic drain();
    while (txQ.size() || cmdQ.size() || wrQ.size() || rxQ.size() || rdQ.size())
      @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  always @(negedge clk) if (run) begin
    if (protoErr) seenErr++;
    // hold checks on state left from the previous cycle
    if (rxHold)  chk(rxValid && rxData == rxSnap, "R11 held rx word", rxData, rxSnap);
    if (wrHold)  chk(wrByteValid && wrByte == wrSnap, "R12 held write byte", wrByte, wrSnap);
    if (cmdHold) chk(cmdValid && {cmdRead, cmdTenBit, cmdAddr, cmdLen} == cmdSnap,
                     "R7 held command", {cmdRead, cmdTenBit, cmdAddr, cmdLen}, cmdSnap);
    txValid     = (txQ.size() > 0) && ($urandom_range(99) < pct);
    txData      = txValid ? txQ[0] : 32'h0;
    cmdReady    = ($urandom_range(99) < pct);
    wrByteReady = ($urandom_range(99) < pct);
    rxReady     = ($urandom_range(99) < pct);
    rdByteValid = (rdQ.size() > 0) && ($urandom_range(99) < pct);
    rdByte      = rdByteValid ? rdQ[0] : 8'h00;
    #1;
    if (txValid && txReady) void'(txQ.pop_front());
    if (rdByteValid && rdByteReady) void'(rdQ.pop_front());
    if (rxValid && rxReady && rdByteValid && rdByteReady) overlapCnt++;
    if (cmdValid && cmdReady) begin
      if (cmdQ.size() == 0) chk(1'b0, "R7 unexpected command", cmdAddr, 0);
      else begin
        cmdExp_t c;
        c = cmdQ.pop_front();
        chk(cmdLen == (LEN_W+1)'(c.len), "R3 length", cmdLen, c.len);
        chk(cmdAddr == c.addr && cmdTenBit == c.ten, "R4 address", {cmdTenBit, cmdAddr}, {c.ten, c.addr});
        chk(cmdEnd == 2'(c.endc), "R5 end action", cmdEnd, c.endc);
        chk(cmdRead == c.rd && {cmdHighSpeed, cmdStartByte, cmdContNak} == c.misc, "R6 flags",
            {cmdRead, cmdHighSpeed, cmdStartByte, cmdContNak}, {c.rd, c.misc});
      end
    end
    if (wrByteValid && wrByteReady) begin
      if (wrQ.size() == 0) chk(1'b0, "R9 byte beyond length", wrByte, 0);
      else begin
        logic [8:0] e;
        e = wrQ.pop_front();
        chk({wrByteLast, wrByte} == e, "R8 R9 write byte order and last", {wrByteLast, wrByte}, e);
      end
    end
    if (rxValid && rxReady) begin
      if (rxQ.size() == 0) chk(1'b0, "R10 unexpected rx word", rxData, 0);
      else begin
        logic [31:0] e;
        e = rxQ.pop_front();
        chk(rxData == e, "R10 packed rx word", rxData, e);
      end
    end
    rxHold = rxValid && !rxReady;           rxSnap = rxData;
    wrHold = wrByteValid && !wrByteReady;   wrSnap = wrByte;
    cmdHold = cmdValid && !cmdReady;        cmdSnap = {cmdRead, cmdTenBit, cmdAddr, cmdLen};
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; txValid = 0; txData = 0; cmdReady = 0; wrByteReady = 0;
    rdByteValid = 0; rdByte = 0; rxReady = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(txReady && !cmdValid && !wrByteValid && !rdByteReady && !rxValid && !protoErr,
        "R1 reset state", {txReady, cmdValid, wrByteValid, rdByteReady, rxValid, protoErr}, 6'b100000);
    @(posedge clk);
    run = 1;
    sendPkt(0, 0, 10'h050, 0, 1, 3'b000);
    sendPkt(0, 0, 10'h03c, 1, 4, 3'b001);
    sendPkt(0, 1, 10'h2a5, 2, 6, 3'b100);
    sendBad();
    sendPkt(1, 0, 10'h021, 3, 5, 3'b010);
    sendPkt(1, 1, 10'h3ff, 0, 8, 3'b000);
    sendPkt(1, 0, 10'h07f, 0, 1, 3'b111);
    drain();
    pct = 55;
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(7) == 0) sendBad();
      sendPkt(1'($urandom_range(1)), 1'($urandom_range(1)), 10'($urandom()),
              $urandom_range(3), $urandom_range(1, 13), 3'($urandom()));
    end
    drain();
    chk(seenErr == expErr, "R2 dropped header count", seenErr, expErr);
    chk(overlapCnt > 0, "R11 drain and take in one cycle", overlapCnt, 1);
    chk(txQ.size() == 0 && wrQ.size() == 0 && rxQ.size() == 0, "R8 R10 all items seen",
        txQ.size() + wrQ.size() + rxQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule